// File: doc/BRIEF.md
# Per-Processor Interrupt Claim Slice

This block is the part of an interrupt controller that belongs to one processor. It watches a set of private interrupt lines, 32 by default. Software gives each line a trigger type. The slice also takes one shared request that a global distributor has already routed to this processor, together with that request's ID. An enable bit is kept for every interrupt ID. Software sets or clears one of these bits by writing the ID, not a bitmask, to a command register.

Servicing follows a claim and complete sequence. A read of the claim register returns the lowest-numbered pending, enabled interrupt that is not already being serviced, and marks it active. That ID is not offered again until software writes it back to the completion register. The processor interrupt output is raised while any interrupt can be claimed and the local enable bit is set. A write to the signal register sends an inter-processor interrupt to a mask of processors. An inter-processor interrupt that arrives from another processor latches the pending bit of the private ID it carries.

All access goes through a simple 32-bit register port. Read data comes back one cycle after the read.

Top module: `lic_slice`

## Requirements
- R1: After reset, irq_o is 0, the control register reads 0, every enable bit is clear, and a claim read returns 0xFFFFFFFF.
- R2: Bit 0 of the control register at offset 0x00 gates irq_o. When the bit is 0, irq_o stays low, but claim reads still return IDs.
- R3: Writing an ID to 0xA0 sets that ID's enable bit, and writing an ID to 0xA4 clears it. An interrupt that is not enabled never raises irq_o and is never returned by a claim, even while it is pending.
- R4: Each private ID has a 2-bit trigger field. IDs 0 to 15 use the word at 0x14 and IDs 16 to 31 use the word at 0x18, with the field at bits [2*(id mod 16)+1 : 2*(id mod 16)]. The encodings are 0 for active-high level, 1 for active-low level, 2 for rising edge and 3 for falling edge. Both words read back what was written.
- R5: An edge-type line latches its pending bit when the selected edge is seen. The pending bit holds after the line returns, and a claim of that ID clears it.
- R6: A level-type line is pending for as long as its input is at the active level. If the line is still active when its completion is written, the ID can be claimed again.
- R7: A claim read at 0x6C returns the lowest pending, enabled, non-active ID and makes that ID active. An active ID is skipped by later claims and by irq_o until its ID is written to 0xB4.
- R8: A claim read when no candidate exists returns 0xFFFFFFFF and changes no state.
- R9: The routed shared request competes under its own ID, which is 32 or higher, and so loses to any private candidate. Claiming it pulses shr_taken together with the read data. Completing it pulses shr_done in the cycle after the write. Only one shared ID can be active at a time.
- R10: A write to 0x60 pulses ipi_tx_valid for one cycle in the cycle after the write. ipi_tx_id carries write bits [3:0] and ipi_tx_mask carries bits [15:8].
- R11: An ipi_rx_valid pulse sets the pending bit of private ID ipi_rx_id, whatever that ID's trigger type, until that ID is claimed.
- R12: Every read produces exactly one bus_rvalid pulse in the following cycle, and writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| line_i | input | NUM_PRIV | Private interrupt lines, synchronous to clk |
| shr_req | input | 1 | Routed shared interrupt request |
| shr_id | input | ID_W | ID of the routed shared request |
| shr_taken | output | 1 | Pulse: the shared request was claimed |
| shr_done | output | 1 | Pulse: the shared request was completed |
| ipi_rx_valid | input | 1 | Incoming inter-processor interrupt |
| ipi_rx_id | input | 4 | Private ID of the incoming inter-processor interrupt |
| ipi_tx_valid | output | 1 | Outgoing inter-processor interrupt pulse |
| ipi_tx_id | output | 4 | ID of the outgoing interrupt |
| ipi_tx_mask | output | NUM_CPU | Target processor mask |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong internal state shows up at the ports by the next claim read. An active bit that is stuck set makes an ID disappear after its completion, and one that is stuck clear makes a claimed ID come back at once. An edge latch that is never cleared returns the same edge ID twice. An edge latch that never sets leaves irq_o low two cycles after the edge, which is when it should have risen. A wrong trigger decode shows as a pending level interrupt at the wrong input level, visible on irq_o one cycle after the line changes. A wrong arbitration order shows as a higher ID returned ahead of a lower one.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the per-processor claim slice.
// Assumes a 12-bit byte address and a 32-bit data register port.
package lic_pkg;
    localparam int LIC_DW = 32;
    localparam int LIC_AW = 12;

    // Register offsets; the IPI field layout and these offsets are fixed by software.
    localparam logic [LIC_AW-1:0] A_CTRL   = 12'h000;
    localparam logic [LIC_AW-1:0] A_TRIG0  = 12'h014;
    localparam logic [LIC_AW-1:0] A_IPI    = 12'h060;
    localparam logic [LIC_AW-1:0] A_CLAIM  = 12'h06C;
    localparam logic [LIC_AW-1:0] A_ENSET  = 12'h0A0;
    localparam logic [LIC_AW-1:0] A_ENCLR  = 12'h0A4;
    localparam logic [LIC_AW-1:0] A_DONE   = 12'h0B4;

    localparam int IPI_ID_W  = 4;
    localparam int IPI_MSK_LSB = 8;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;
endpackage

// File: rtl/lic_trig_detect.sv
`timescale 1ns/1ps
// Trigger detector: samples each private line, decodes its 2-bit trigger
// type and produces a pending bit. Edge and IPI events latch until the
// claim clears them; level types follow the sampled line.
// Assumes lines are already synchronous to clk.
module lic_trig_detect
    import lic_pkg::*;
#(
    parameter int NUM_PRIV = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PRIV-1:0]   line_i,
    input  logic [2*NUM_PRIV-1:0] trig_cfg,
    input  logic [NUM_PRIV-1:0]   set_vec,
    input  logic [NUM_PRIV-1:0]   clr_vec,
    output logic [NUM_PRIV-1:0]   pend_o
);
    for (genvar i = 0; i < NUM_PRIV; i++) begin : g_line
        logic  smp_q, smp_qq, latch_q;
        logic  is_edge_hit, lvl_act;
        trig_e kind;

        assign kind = trig_e'(trig_cfg[2*i +: 2]);

        // Two-stage sample of the line for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q  <= 1'b0;
                smp_qq <= 1'b0;
            end else begin
                smp_q  <= line_i[i];
                smp_qq <= smp_q;
            end
        end

        // Decode the selected edge or active level.
        always_comb begin
            is_edge_hit = ((kind == TRIG_RISE) &&  smp_q && !smp_qq) ||
                          ((kind == TRIG_FALL) && !smp_q &&  smp_qq);
            lvl_act     = ((kind == TRIG_LVL_HI) &&  smp_q) ||
                          ((kind == TRIG_LVL_LO) && !smp_q);
        end

        // Latched pending: a new event wins over a same-cycle claim clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                        latch_q <= 1'b0;
            else if (is_edge_hit || set_vec[i]) latch_q <= 1'b1;
            else if (clr_vec[i])               latch_q <= 1'b0;
        end

        assign pend_o[i] = lvl_act | latch_q;
    end
endmodule

// File: rtl/lic_claim_arb.sv
`timescale 1ns/1ps
// Claim arbiter: fixed priority, lowest index wins. Purely combinational.
// Assumes the caller orders candidates so that a lower index is a lower ID.
module lic_claim_arb #(
    parameter int N     = 33,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set request is left in idx.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/lic_regs.sv
`timescale 1ns/1ps
// Register file: control enable, trigger words, per-ID enable bits set and
// cleared by ID commands, and the outgoing IPI pulse. Produces plain read
// data for non-claim offsets. Assumes NUM_PRIV is a multiple of 16.
module lic_regs
    import lic_pkg::*;
#(
    parameter int NUM_PRIV = 32,
    parameter int NUM_IDS  = 256,
    parameter int NUM_CPU  = 8,
    parameter int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [LIC_AW-1:0]     bus_addr,
    input  logic [LIC_DW-1:0]     bus_wdata,
    output logic [LIC_DW-1:0]     reg_rdata,
    output logic                  ctrl_en,
    output logic [2*NUM_PRIV-1:0] trig_cfg,
    output logic [NUM_IDS-1:0]    en_vec,
    output logic                  ipi_tx_valid,
    output logic [IPI_ID_W-1:0]   ipi_tx_id,
    output logic [NUM_CPU-1:0]    ipi_tx_mask
);
    localparam int CFG_WORDS = (2 * NUM_PRIV) / LIC_DW;

    logic            wr_hit, id_ok;
    logic [ID_W-1:0] cmd_id;
    logic [LIC_DW-1:0] cfg_q [CFG_WORDS];

    assign wr_hit = bus_sel && bus_wr;
    assign id_ok  = bus_wdata < LIC_DW'(NUM_IDS);
    assign cmd_id = bus_wdata[ID_W-1:0];

    // Local controller enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_en <= 1'b0;
        else if (wr_hit && bus_addr == A_CTRL) ctrl_en <= bus_wdata[0];
    end

    // Trigger configuration words, one per 16 private IDs.
    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) cfg_q[w] <= '0;
            else if (wr_hit && bus_addr == A_TRIG0 + LIC_AW'(4 * w)) cfg_q[w] <= bus_wdata;
        end
        assign trig_cfg[LIC_DW*w +: LIC_DW] = cfg_q[w];
    end

    // Per-ID enable bits, changed one ID per command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_vec <= '0;
        end else if (wr_hit && id_ok) begin
            if (bus_addr == A_ENSET) en_vec[cmd_id] <= 1'b1;
            if (bus_addr == A_ENCLR) en_vec[cmd_id] <= 1'b0;
        end
    end

    // Outgoing inter-processor interrupt, a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipi_tx_valid <= 1'b0;
            ipi_tx_id    <= '0;
            ipi_tx_mask  <= '0;
        end else begin
            ipi_tx_valid <= wr_hit && bus_addr == A_IPI;
            if (wr_hit && bus_addr == A_IPI) begin
                ipi_tx_id   <= bus_wdata[IPI_ID_W-1:0];
                ipi_tx_mask <= bus_wdata[IPI_MSK_LSB +: NUM_CPU];
            end
        end
    end

    // Read mux for the plain registers; others read as zero.
    always_comb begin
        reg_rdata = '0;
        if (bus_addr == A_CTRL) reg_rdata[0] = ctrl_en;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (bus_addr == A_TRIG0 + LIC_AW'(4 * w)) reg_rdata = cfg_q[w];
        end
    end
endmodule

// File: rtl/lic_slice.sv
`timescale 1ns/1ps
// Per-processor interrupt claim slice: combines pending state from the
// trigger detector with enable and active bits, arbitrates the lowest ID,
// and handles claim reads and completion writes. Assumes the shared ID
// presented by the distributor is at least NUM_PRIV when shr_req is high.
module lic_slice
    import lic_pkg::*;
#(
    parameter int NUM_PRIV = 32,
    parameter int NUM_IDS  = 256,
    parameter int NUM_CPU  = 8,
    parameter int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PRIV-1:0] line_i,
    input  logic                shr_req,
    input  logic [ID_W-1:0]     shr_id,
    output logic                shr_taken,
    output logic                shr_done,
    input  logic                ipi_rx_valid,
    input  logic [3:0]          ipi_rx_id,
    output logic                ipi_tx_valid,
    output logic [3:0]          ipi_tx_id,
    output logic [NUM_CPU-1:0]  ipi_tx_mask,
    output logic                irq_o
);
    localparam int NCAND = NUM_PRIV + 1;
    localparam int IDX_W = $clog2(NCAND);

    logic                  ctrl_en;
    logic [2*NUM_PRIV-1:0] trig_cfg;
    logic [NUM_IDS-1:0]    en_vec;
    logic [LIC_DW-1:0]     reg_rdata;
    logic [NUM_PRIV-1:0]   pend, set_vec, clr_vec, priv_act, priv_cand;
    logic                  shr_act, shr_cand;
    logic [ID_W-1:0]       shr_act_id, win_id, done_id;
    logic [NCAND-1:0]      cand;
    logic                  found, claim_rd, claim_go, win_shr, done_hit;
    logic [IDX_W-1:0]      win_idx;

    lic_regs #(
        .NUM_PRIV(NUM_PRIV), .NUM_IDS(NUM_IDS), .NUM_CPU(NUM_CPU), .ID_W(ID_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_rdata(reg_rdata),
        .ctrl_en(ctrl_en), .trig_cfg(trig_cfg), .en_vec(en_vec),
        .ipi_tx_valid(ipi_tx_valid), .ipi_tx_id(ipi_tx_id), .ipi_tx_mask(ipi_tx_mask)
    );

    lic_trig_detect #(.NUM_PRIV(NUM_PRIV)) trig_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .trig_cfg(trig_cfg),
        .set_vec(set_vec), .clr_vec(clr_vec), .pend_o(pend)
    );

    lic_claim_arb #(.N(NCAND), .IDX_W(IDX_W)) arb_i (
        .req(cand), .found(found), .idx(win_idx)
    );

    // Candidate vector: private IDs in order, the shared request last.
    always_comb begin
        priv_cand = pend & en_vec[NUM_PRIV-1:0] & ~priv_act;
        shr_cand  = shr_req && en_vec[shr_id] && !shr_act && (shr_id >= ID_W'(NUM_PRIV));
        cand      = {shr_cand, priv_cand};
        win_shr   = found && (win_idx == IDX_W'(NUM_PRIV));
        win_id    = win_shr ? shr_id : ID_W'(win_idx);
    end

    // Claim read and completion write decode.
    always_comb begin
        claim_rd = bus_sel && !bus_wr && bus_addr == A_CLAIM;
        claim_go = claim_rd && found;
        done_hit = bus_sel && bus_wr && bus_addr == A_DONE && (bus_wdata < 32'(NUM_IDS));
        done_id  = bus_wdata[ID_W-1:0];
    end

    // Per-line claim clear and incoming IPI set strobes.
    for (genvar i = 0; i < NUM_PRIV; i++) begin : g_strobe
        assign clr_vec[i] = claim_go && !win_shr && (win_idx == IDX_W'(i));
        assign set_vec[i] = ipi_rx_valid && ({{(ID_W-4){1'b0}}, ipi_rx_id} == ID_W'(i));
    end

    // Private active bits: set by claim, cleared by completion of that ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_act <= '0;
        end else begin
            for (int i = 0; i < NUM_PRIV; i++) begin
                if (clr_vec[i])                             priv_act[i] <= 1'b1;
                else if (done_hit && done_id == ID_W'(i))   priv_act[i] <= 1'b0;
            end
        end
    end

    // Single active slot for the shared request and its handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_act    <= 1'b0;
            shr_act_id <= '0;
            shr_taken  <= 1'b0;
            shr_done   <= 1'b0;
        end else begin
            shr_taken <= claim_go && win_shr;
            shr_done  <= done_hit && shr_act && done_id == shr_act_id;
            if (claim_go && win_shr) begin
                shr_act    <= 1'b1;
                shr_act_id <= shr_id;
            end else if (done_hit && shr_act && done_id == shr_act_id) begin
                shr_act <= 1'b0;
            end
        end
    end

    // Registered read return: claim result or plain register value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            if (bus_sel && !bus_wr) begin
                if (claim_rd) bus_rdata <= found ? 32'(win_id) : '1;
                else          bus_rdata <= reg_rdata;
            end
        end
    end

    assign irq_o = ctrl_en && found;
endmodule

// File: rtl/lic_slice_chk.sv
`timescale 1ns/1ps
// Checker for lic_slice: port-level timing properties, bound to the top.
module lic_slice_chk
    import lic_pkg::*;
#(
    parameter int NUM_PRIV = 32,
    parameter int NUM_IDS  = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        ipi_tx_valid,
    input logic [3:0]  ipi_tx_id,
    input logic        shr_taken,
    input logic        irq_o
);
    // R12: a read returns data in the next cycle.
    a_r12_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R12: no read data without a read.
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    // R10: IPI write yields a pulse carrying the written ID.
    a_r10_ipi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_IPI) |=> (ipi_tx_valid && ipi_tx_id == $past(bus_wdata[3:0])));

    // R10: no IPI pulse without an IPI write.
    a_r10_ipi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_IPI) |=> !ipi_tx_valid);

    // R2: clearing the local enable silences the interrupt output.
    a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_CTRL && !bus_wdata[0]) |=> !irq_o);

    // R7 / R8: a claim returns a legal ID or the all-ones code.
    a_r7_claim_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr) == A_CLAIM) |-> (bus_rdata < 32'(NUM_IDS) || bus_rdata == '1));

    // R9: the shared handshake pulse comes with a shared ID on the read port.
    a_r9_taken_id: assert property (@(posedge clk) disable iff (!rst_n)
        shr_taken |-> (bus_rvalid && bus_rdata >= 32'(NUM_PRIV) && bus_rdata < 32'(NUM_IDS)));
endmodule

bind lic_slice lic_slice_chk #(.NUM_PRIV(NUM_PRIV), .NUM_IDS(NUM_IDS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ipi_tx_valid(ipi_tx_valid), .ipi_tx_id(ipi_tx_id),
    .shr_taken(shr_taken), .irq_o(irq_o)
);

// File: tb/lic_slice_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module lic_slice_tb_top;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] line_i = '0;
    logic        shr_req = 1'b0;
    logic [7:0]  shr_id = '0;
    logic        shr_taken, shr_done;
    logic        ipi_rx_valid = 1'b0;
    logic [3:0]  ipi_rx_id = '0;
    logic        ipi_tx_valid;
    logic [3:0]  ipi_tx_id;
    logic [7:0]  ipi_tx_mask;
    logic        irq_o;

    int n_tests = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    lic_slice dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .line_i(line_i), .shr_req(shr_req),
        .shr_id(shr_id), .shr_taken(shr_taken), .shr_done(shr_done),
        .ipi_rx_valid(ipi_rx_valid), .ipi_rx_id(ipi_rx_id),
        .ipi_tx_valid(ipi_tx_valid), .ipi_tx_id(ipi_tx_id),
        .ipi_tx_mask(ipi_tx_mask), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every read return is compared against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic claim(input logic [31:0] exp, input string tag);
        rd(12'h06C, exp, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 irq after reset", 32'(irq_o), 0);
        rd(12'h000, 0, "R1 ctrl after reset");
        claim(NONE, "R1 R8 claim after reset");
        wr(12'h000, 1);
        check("R12 no rvalid on write", 32'(bus_rvalid), 0);
        rd(12'h000, 1, "R2 ctrl readback");

        // R3: pending but disabled is invisible.
        line_i[5] = 1'b1; @(negedge clk);
        check("R3 disabled no irq", 32'(irq_o), 0);
        claim(NONE, "R3 disabled no claim");
        wr(12'h0A0, 5);
        check("R3 enabled irq", 32'(irq_o), 1);
        wr(12'h000, 0);
        check("R2 gated irq", 32'(irq_o), 0);
        claim(5, "R2 claim without local enable");
        claim(NONE, "R7 active skipped");
        wr(12'h000, 1);
        check("R7 active no irq", 32'(irq_o), 0);
        wr(12'h0B4, 5);
        check("R6 level re-pends", 32'(irq_o), 1);
        claim(5, "R6 reclaim level");
        line_i[5] = 1'b0; @(negedge clk);
        wr(12'h0B4, 5);
        claim(NONE, "R6 level released");

        // R7: lowest ID first.
        line_i[9] = 1'b1; line_i[3] = 1'b1;
        wr(12'h0A0, 9); wr(12'h0A0, 3);
        claim(3, "R7 lowest first");
        claim(9, "R7 next");
        claim(NONE, "R8 all active");
        line_i[9] = 1'b0; line_i[3] = 1'b0; @(negedge clk);
        wr(12'h0B4, 3); wr(12'h0B4, 9);
        claim(NONE, "R8 empty");

        // R4: active-low level on ID 7 (bits 15:14 of word 0x14).
        wr(12'h014, 32'h0000_4000);
        rd(12'h014, 32'h0000_4000, "R4 cfg readback");
        wr(12'h0A0, 7);
        claim(7, "R4 level low pending");
        wr(12'h0B4, 7);
        wr(12'h0A4, 7);
        check("R3 disable drops irq", 32'(irq_o), 0);
        claim(NONE, "R3 disabled after disable write");

        // R5: rising edge on ID 20 (bits 9:8 of word 0x18).
        wr(12'h018, 32'h0000_0200);
        rd(12'h018, 32'h0000_0200, "R4 cfg word1 readback");
        wr(12'h0A0, 20);
        line_i[20] = 1'b1; repeat (2) @(negedge clk);
        check("R5 rise irq", 32'(irq_o), 1);
        claim(20, "R5 rise claim");
        wr(12'h0B4, 20);
        claim(NONE, "R5 claim cleared edge");
        wr(12'h018, 32'h0000_0300);
        line_i[20] = 1'b0; repeat (2) @(negedge clk);
        claim(20, "R5 fall claim");
        wr(12'h0B4, 20);
        wr(12'h018, 32'h0000_0200);
        line_i[20] = 1'b1; @(negedge clk); line_i[20] = 1'b0;
        repeat (3) @(negedge clk);
        claim(20, "R5 short pulse latched");
        wr(12'h0B4, 20);
        claim(NONE, "R5 pulse consumed");

        // R11: incoming IPI on ID 15.
        wr(12'h014, 32'h8000_0000);
        wr(12'h0A0, 15);
        ipi_rx_id = 4'd15; ipi_rx_valid = 1'b1; @(negedge clk); ipi_rx_valid = 1'b0;
        check("R11 ipi irq", 32'(irq_o), 1);
        claim(15, "R11 ipi claim");
        wr(12'h0B4, 15);
        claim(NONE, "R11 ipi consumed");

        // R10: outgoing IPI.
        wr(12'h060, 32'h0000_A50F);
        check("R10 tx valid", 32'(ipi_tx_valid), 1);
        check("R10 tx id", 32'(ipi_tx_id), 32'hF);
        check("R10 tx mask", 32'(ipi_tx_mask), 32'hA5);
        @(negedge clk);
        check("R10 single pulse", 32'(ipi_tx_valid), 0);

        // R9: shared request loses to private, one active slot.
        shr_id = 8'd40; shr_req = 1'b1;
        line_i[2] = 1'b1;
        wr(12'h0A0, 40); wr(12'h0A0, 2);
        claim(2, "R9 private beats shared");
        claim(40, "R9 shared claim");
        check("R9 shr_taken", 32'(shr_taken), 1);
        claim(NONE, "R9 shared active");
        check("R9 shr_taken pulse ends", 32'(shr_taken), 0);
        line_i[2] = 1'b0; @(negedge clk);
        wr(12'h0B4, 2);
        check("R9 no done for private", 32'(shr_done), 0);
        wr(12'h0B4, 40);
        check("R9 shr_done", 32'(shr_done), 1);
        shr_req = 1'b0; @(negedge clk);
        check("R9 shr_done pulse ends", 32'(shr_done), 0);
        claim(NONE, "R9 nothing left");

        repeat (2) @(negedge clk);
        check("R12 every read returned", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule